// File: doc/BRIEF.md
# Lowest-Priority Interrupt Distribution Arbiter

This block takes one external interrupt request and decides which of up to sixteen processor ports should receive it. It has two delivery modes. In static mode the interrupt is copied to every processor named in a destination mask. That can be one processor, a group, or every processor at once. Each selected processor gets the interrupt; there is no winner selection. In dynamic mode exactly one processor receives it: the eligible one whose task priority is lowest.

Each processor has a 4-bit task priority held inside the block. Software sets these values through a small write port, and they normally change at every context switch. Processors can tie on task priority. Ties are resolved by a 4-bit arbitration rank that the block keeps for each processor and updates after every dynamic delivery. Because of this update, processors with equal task priority take turns receiving interrupts. The result appears as a registered one-hot or multi-hot delivery vector together with a single-cycle valid strobe.

The parameter `NUM_CPU` ranges from 2 to 16. The upper limit exists because the ranks are 4 bits wide and must stay distinct.

Top module: `irq_dist_arbiter`

## Requirements
- R1: After reset, `deliver_o` is zero, `valid_o` is low, every task priority is 0, and processor i holds arbitration rank i.
- R2: A request with `mode_i` = 0 (static) yields `deliver_o` equal to `dest_mask_i` and `valid_o` high on the clock edge after the request edge.
- R3: A static request with an all-zero mask produces no delivery: `valid_o` stays low and `deliver_o` stays zero.
- R4: A request with `mode_i` = 1 (dynamic) delivers to exactly one processor, and that processor is set in the mask. Among the masked processors, it has the lowest task priority.
- R5: When several masked processors share the lowest task priority, the one with the highest arbitration rank wins.
- R6: After a dynamic delivery, the winner's rank becomes 0 and every other processor's rank rises by one.
- R7: A rank that would rise past 15 is instead set to the winner's rank before the update plus one.
- R8: A dynamic request with an empty mask produces no delivery and leaves every rank unchanged.
- R9: Static deliveries and idle cycles leave the arbitration ranks unchanged.
- R10: A write on the task priority port (index, 4-bit value, enable) takes effect for requests on later edges. A request on the same edge as the write still sees the old value.
- R11: On an edge without a request, the next `deliver_o` is zero and `valid_o` is low.
- R12: The arbitration ranks of all processors are always pairwise distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Interrupt request, one cycle per event |
| mode_i | input | 1 | 0 = static to mask, 1 = dynamic lowest priority |
| dest_mask_i | input | NUM_CPU | Destination or eligibility mask |
| tpr_we_i | input | 1 | Task priority write enable |
| tpr_idx_i | input | $clog2(NUM_CPU) | Processor whose task priority is written |
| tpr_data_i | input | PRIO_W | New task priority value |
| deliver_o | output | NUM_CPU | Registered delivery vector |
| valid_o | output | 1 | Registered delivery strobe |

## Verification
The checker relies on `req_i`, `mode_i` and `dest_mask_i` being known values at every clock edge once reset is released. It also relies on the write index never exceeding `NUM_CPU-1`. The bench drives every input from a fixed-seed random source. Each input changes only on the falling edge. Write indices are drawn only inside the processor range.

Task priorities are drawn from a narrow range so that ties, and therefore rank-based selection and the wrap rule, occur often. Directed steps force the empty-mask cases and same-edge writes.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

    // Width of the per-processor arbitration rank; ranks stay distinct, so
    // at most 2**ARB_RANK_W processors can be served.
    localparam int ARB_RANK_W = 4;

    typedef enum logic {
        DELIV_STATIC  = 1'b0,
        DELIV_DYNAMIC = 1'b1
    } deliv_mode_e;

endpackage

// File: rtl/irq_tpr_bank.sv
// Per-processor task priority storage with a single write port.
module irq_tpr_bank #(
    parameter int NUM_CPU = 16,
    parameter int PRIO_W  = 4,
    parameter int IDX_W   = $clog2(NUM_CPU)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we_i,
    input  logic [IDX_W-1:0]                idx_i,
    input  logic [PRIO_W-1:0]               data_i,
    output logic [NUM_CPU-1:0][PRIO_W-1:0]  tpr_o
);

    typedef struct packed {
        logic [NUM_CPU-1:0][PRIO_W-1:0] tpr;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            for (int i = 0; i < NUM_CPU; i++) begin
                if (idx_i == IDX_W'(i)) begin
                    st_d.tpr[i] = data_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tpr_o = st_q.tpr;

endmodule

// File: rtl/irq_lowprio_pick.sv
// Comparison tree: among eligible processors pick the lowest task priority,
// breaking ties by the highest arbitration rank. Key = {~tpr, rank}; the
// largest key wins. Ranks are distinct, so keys of eligible leaves never tie.
module irq_lowprio_pick #(
    parameter int NUM_CPU = 16,
    parameter int PRIO_W  = 4,
    parameter int ARB_W   = 4,
    parameter int IDX_W   = $clog2(NUM_CPU)
) (
    input  logic [NUM_CPU-1:0]              elig_i,
    input  logic [NUM_CPU-1:0][PRIO_W-1:0]  tpr_i,
    input  logic [NUM_CPU-1:0][ARB_W-1:0]   arb_i,
    output logic                            any_o,
    output logic [IDX_W-1:0]                win_idx_o,
    output logic [NUM_CPU-1:0]              win_oh_o
);

    localparam int LVL    = $clog2(NUM_CPU);
    localparam int LEAVES = 1 << LVL;
    localparam int KEY_W  = PRIO_W + ARB_W;

    for (genvar l = 0; l <= LVL; l++) begin : g_lvl
        localparam int W = LEAVES >> l;
        logic [W-1:0]            vld;
        logic [W-1:0][KEY_W-1:0] key;
        logic [W-1:0][IDX_W-1:0] idx;

        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < W; i++) begin : g_in
                if (i < NUM_CPU) begin : g_real
                    assign vld[i] = elig_i[i];
                    assign key[i] = {~tpr_i[i], arb_i[i]};
                    assign idx[i] = IDX_W'(i);
                end else begin : g_pad
                    assign vld[i] = 1'b0;
                    assign key[i] = '0;
                    assign idx[i] = '0;
                end
            end
        end else begin : g_node
            for (genvar i = 0; i < W; i++) begin : g_cmp
                logic take_l;
                assign take_l = g_lvl[l-1].vld[2*i] &&
                                (!g_lvl[l-1].vld[2*i+1] ||
                                 (g_lvl[l-1].key[2*i] >= g_lvl[l-1].key[2*i+1]));
                assign vld[i] = g_lvl[l-1].vld[2*i] | g_lvl[l-1].vld[2*i+1];
                assign key[i] = take_l ? g_lvl[l-1].key[2*i] : g_lvl[l-1].key[2*i+1];
                assign idx[i] = take_l ? g_lvl[l-1].idx[2*i] : g_lvl[l-1].idx[2*i+1];
            end
        end
    end

    assign any_o     = g_lvl[LVL].vld[0];
    assign win_idx_o = g_lvl[LVL].idx[0];

    always_comb begin
        for (int i = 0; i < NUM_CPU; i++) begin
            win_oh_o[i] = any_o && (win_idx_o == IDX_W'(i));
        end
    end

endmodule

// File: rtl/irq_arb_rotor.sv
// Self-updating arbitration ranks. On an update the winner drops to 0,
// all others rise by one, and a rank at the ceiling wraps to
// (winner's old rank + 1), which is the single value left free.
module irq_arb_rotor #(
    parameter int NUM_CPU = 16,
    parameter int ARB_W   = 4,
    parameter int IDX_W   = $clog2(NUM_CPU)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           upd_i,
    input  logic [IDX_W-1:0]               win_idx_i,
    output logic [NUM_CPU-1:0][ARB_W-1:0]  arb_o
);

    localparam logic [ARB_W-1:0] ARB_MAX = {ARB_W{1'b1}};
    localparam logic [ARB_W-1:0] ARB_ONE = ARB_W'(1);

    typedef struct packed {
        logic [NUM_CPU-1:0][ARB_W-1:0] arb;
    } rotor_t;

    function automatic rotor_t reset_ranks();
        rotor_t r;
        for (int i = 0; i < NUM_CPU; i++) begin
            r.arb[i] = ARB_W'(i);
        end
        return r;
    endfunction

    localparam rotor_t RST_VAL = reset_ranks();

    rotor_t           st_d, st_q;
    logic [ARB_W-1:0] win_old;

    always_comb begin
        st_d    = st_q;
        win_old = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (win_idx_i == IDX_W'(i)) begin
                win_old = st_q.arb[i];
            end
        end
        if (upd_i) begin
            for (int i = 0; i < NUM_CPU; i++) begin
                if (win_idx_i == IDX_W'(i)) begin
                    st_d.arb[i] = '0;
                end else if (st_q.arb[i] == ARB_MAX) begin
                    st_d.arb[i] = win_old + ARB_ONE;
                end else begin
                    st_d.arb[i] = st_q.arb[i] + ARB_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign arb_o = st_q.arb;

endmodule

// File: rtl/irq_dist_arbiter.sv
// Top: static or lowest-priority delivery of one interrupt request.
module irq_dist_arbiter #(
    parameter int NUM_CPU = 16,
    parameter int PRIO_W  = 4,
    parameter int IDX_W   = $clog2(NUM_CPU)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               mode_i,
    input  logic [NUM_CPU-1:0] dest_mask_i,
    input  logic               tpr_we_i,
    input  logic [IDX_W-1:0]   tpr_idx_i,
    input  logic [PRIO_W-1:0]  tpr_data_i,
    output logic [NUM_CPU-1:0] deliver_o,
    output logic               valid_o
);

    import irq_dist_pkg::*;

    localparam int ARB_W = ARB_RANK_W;

    typedef struct packed {
        logic [NUM_CPU-1:0] deliver;
        logic               valid;
    } out_t;

    logic [NUM_CPU-1:0][PRIO_W-1:0] tpr;
    logic [NUM_CPU-1:0][ARB_W-1:0]  arb_prio;
    logic                           pick_any;
    logic [IDX_W-1:0]               pick_idx;
    logic [NUM_CPU-1:0]             pick_oh;
    logic                           rot_upd;
    deliv_mode_e                    mode;
    out_t                           out_d, out_q;

    assign mode = deliv_mode_e'(mode_i);

    irq_tpr_bank #(
        .NUM_CPU (NUM_CPU),
        .PRIO_W  (PRIO_W),
        .IDX_W   (IDX_W)
    ) u_tpr (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (tpr_we_i),
        .idx_i  (tpr_idx_i),
        .data_i (tpr_data_i),
        .tpr_o  (tpr)
    );

    irq_lowprio_pick #(
        .NUM_CPU (NUM_CPU),
        .PRIO_W  (PRIO_W),
        .ARB_W   (ARB_W),
        .IDX_W   (IDX_W)
    ) u_pick (
        .elig_i    (dest_mask_i),
        .tpr_i     (tpr),
        .arb_i     (arb_prio),
        .any_o     (pick_any),
        .win_idx_o (pick_idx),
        .win_oh_o  (pick_oh)
    );

    irq_arb_rotor #(
        .NUM_CPU (NUM_CPU),
        .ARB_W   (ARB_W),
        .IDX_W   (IDX_W)
    ) u_rotor (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_i     (rot_upd),
        .win_idx_i (pick_idx),
        .arb_o     (arb_prio)
    );

    // Ranks move only when a dynamic request actually found a target.
    assign rot_upd = req_i && (mode == DELIV_DYNAMIC) && pick_any;

    always_comb begin
        out_d = '0;
        if (req_i) begin
            if (mode == DELIV_STATIC) begin
                out_d.deliver = dest_mask_i;
                out_d.valid   = |dest_mask_i;
            end else begin
                out_d.deliver = pick_oh;
                out_d.valid   = pick_any;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign deliver_o = out_q.deliver;
    assign valid_o   = out_q.valid;

endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk #(
    parameter int NUM_CPU = 16,
    parameter int ARB_W   = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_i,
    input logic                          mode_i,
    input logic [NUM_CPU-1:0]            dest_mask_i,
    input logic [NUM_CPU-1:0]            deliver_o,
    input logic                          valid_o,
    input logic [NUM_CPU-1:0][ARB_W-1:0] arb_prio
);

    logic                   past_ok;
    logic [NUM_CPU-1:0]     zero_rank;
    logic [(1<<ARB_W)-1:0]  rank_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_comb begin
        rank_seen = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            zero_rank[i]           = (arb_prio[i] == '0);
            rank_seen[arb_prio[i]] = 1'b1;
        end
    end

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !$past(req_i) |-> (!valid_o && deliver_o == '0));

    // R2
    static_copy_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(req_i && !mode_i) |-> (deliver_o == $past(dest_mask_i) && valid_o == |$past(dest_mask_i)));

    // R4
    dyn_single_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(req_i && mode_i) |-> ($onehot0(deliver_o) && (deliver_o & ~$past(dest_mask_i)) == '0
                                     && valid_o == (deliver_o != '0)));

    // R8
    dyn_empty_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(req_i && mode_i && dest_mask_i == '0) |-> (!valid_o && $stable(arb_prio)));

    // R9
    rank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(!req_i || !mode_i) |-> $stable(arb_prio));

    // R6
    winner_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (valid_o && $past(mode_i)) |-> (zero_rank == deliver_o));

    // R12
    rank_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rank_seen) == NUM_CPU);

endmodule

bind irq_dist_arbiter irq_dist_chk #(
    .NUM_CPU (NUM_CPU),
    .ARB_W   (irq_dist_pkg::ARB_RANK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .mode_i      (mode_i),
    .dest_mask_i (dest_mask_i),
    .deliver_o   (deliver_o),
    .valid_o     (valid_o),
    .arb_prio    (arb_prio)
);

// File: tb/sim_irq_dist_arbiter.sv
`timescale 1ns/1ps
module sim_irq_dist_arbiter;

    localparam int N     = 16;
    localparam int IDX_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_i = 1'b0;
    logic             mode_i = 1'b0;
    logic [N-1:0]     dest_mask_i = '0;
    logic             tpr_we_i = 1'b0;
    logic [IDX_W-1:0] tpr_idx_i = '0;
    logic [3:0]       tpr_data_i = '0;
    logic [N-1:0]     deliver_o;
    logic             valid_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int           tpr_m [N];
    int           arb_m [N];
    logic [N-1:0] exp_vec = '0;
    logic         exp_vld = 1'b0;
    string        cur_tag = "R1 R11";

    always #4 clk = ~clk;

    irq_dist_arbiter #(.NUM_CPU(N), .PRIO_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
        .dest_mask_i(dest_mask_i), .tpr_we_i(tpr_we_i), .tpr_idx_i(tpr_idx_i),
        .tpr_data_i(tpr_data_i), .deliver_o(deliver_o), .valid_o(valid_o)
    );

    // Lowest task priority among masked, ties to highest rank (R4, R5).
    function automatic int model_pick(logic [N-1:0] m);
        int best = -1;
        for (int i = 0; i < N; i++) begin
            if (m[i]) begin
                if (best < 0 || tpr_m[i] < tpr_m[best] ||
                    (tpr_m[i] == tpr_m[best] && arb_m[i] > arb_m[best]))
                    best = i;
            end
        end
        return best;
    endfunction

    // Rank update (R6) including the ceiling wrap (R7).
    function automatic void model_rotate(int w);
        int old = arb_m[w];
        for (int i = 0; i < N; i++) begin
            if (i == w)              arb_m[i] = 0;
            else if (arb_m[i] == 15) arb_m[i] = old + 1;
            else                     arb_m[i] = arb_m[i] + 1;
        end
    endfunction

    task automatic check_prev();
        n_chk++;
        if (deliver_o !== exp_vec || valid_o !== exp_vld) begin
            n_bad++;
            $display("FAIL %s: actual vec=%h vld=%b expected vec=%h vld=%b",
                     cur_tag, deliver_o, valid_o, exp_vec, exp_vld);
        end
    endtask

    // One cycle: check the result of the last edge, then drive the next one.
    task automatic step(input logic r, input logic md, input logic [N-1:0] m,
                        input logic we, input int ix, input int dt, input string tag);
        int w;
        @(negedge clk);
        check_prev();
        req_i = r; mode_i = md; dest_mask_i = m;
        tpr_we_i = we; tpr_idx_i = IDX_W'(ix); tpr_data_i = 4'(dt);
        exp_vec = '0; exp_vld = 1'b0;
        if (r && !md) begin
            exp_vec = m; exp_vld = |m;
        end else if (r && md) begin
            w = model_pick(m);       // uses pre-write priorities (R10)
            if (w >= 0) begin
                exp_vec[w] = 1'b1; exp_vld = 1'b1;
                model_rotate(w);
            end
        end
        if (we) tpr_m[ix] = dt;
        cur_tag = tag;
    endtask

    localparam logic [N-1:0] FULL = '1;

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin tpr_m[i] = 0; arb_m[i] = i; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset ranks, all priorities zero -> CPU15 first, then CPU14.
        step(1, 1, FULL, 0, 0, 0, "R1 R5");
        step(1, 1, FULL, 0, 0, 0, "R6 R5");
        // R2 static subset, then dynamic unaffected by it (R9).
        step(1, 0, 16'hA5A5, 0, 0, 0, "R2");
        step(1, 1, FULL, 0, 0, 0, "R9");
        step(1, 0, FULL, 0, 0, 0, "R2 broadcast");
        step(1, 0, '0, 0, 0, 0, "R3");
        step(1, 1, '0, 0, 0, 0, "R8");
        step(1, 1, FULL, 0, 0, 0, "R8 ranks held");
        step(0, 1, FULL, 0, 0, 0, "R11");
        // Raise everyone to 8, then lower CPU2 on the same edge as a request.
        for (int i = 0; i < N; i++) step(0, 0, '0, 1, i, 8, "R11");
        step(1, 1, FULL, 1, 2, 3, "R10 old value");
        step(1, 1, FULL, 0, 0, 0, "R10 new value R4");
        // CPU2 won from a middle rank; the ceiling rank wrapped.
        step(1, 1, FULL, 0, 0, 0, "R7");
        step(1, 1, 16'h00F0, 0, 0, 0, "R7 R5");
        step(1, 1, 16'h0004, 0, 0, 0, "R4 single");
        step(0, 0, '0, 0, 0, 0, "R11");

        // Random phase with narrow priorities to create ties.
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] m;
            logic r, md, we;
            int sel;
            sel = int'($urandom_range(0, 7));
            m = (sel == 0) ? '0 : (sel == 1) ? FULL : N'($urandom);
            r  = ($urandom_range(0, 99) < 60);
            md = $urandom_range(0, 1) == 1;
            we = ($urandom_range(0, 99) < 30);
            step(r, md, m, we, int'($urandom_range(0, N-1)), int'($urandom_range(0, 3)),
                 !r ? "R11" : (!md ? "R2 R3 R9" : "R4 R5 R6 R7 R8 R10 R12"));
        end
        step(0, 0, '0, 0, 0, 0, "R11");
        @(negedge clk);
        check_prev();

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule